// File: doc/BRIEF.md
# Harvard Accumulator Core

A small multi-cycle processor built around one accumulator. Its program and its data live in two separate memories inside the block. Each instruction takes two consecutive program words: an opcode word, then an operand word that holds a data address, a device number or a jump target. The core walks through an explicit fetch and execute sequence. A program-side address/data register pair feeds the fetch. A data-side address/data register pair sits between the accumulator and data memory.

Programs are written through a load port while the core is held in reset. Once reset is released, the core runs from word 0. Operand input and result output are exchanged with the surroundings through valid/ready handshakes. Each completed instruction raises a one-cycle retire pulse that carries the program counter and the accumulator, so a surrounding bench can follow the state trace. The END opcode stops the core, and so does any opcode it does not know. Only a reset restarts it.

Top module: `hacc_core`

## Requirements
- R1: After reset the program counter is 0. Every fetch reads the opcode word at PC and the operand word at PC+1, then advances PC by 2. PC is 8 bits wide and wraps modulo 256. A program word at index 250 or above reads as 0.
- R2: Opcode 1 (load) sets the accumulator to the data word at the operand address.
- R3: Opcode 2 (add) and opcode 4 (subtract) set the accumulator to accumulator plus, or minus, the addressed data word, in 32-bit two's complement.
- R4: Opcode 3 (store) writes the accumulator into data memory at the operand address. A later load from that address returns it.
- R5: Opcode 5 (input) raises in_ready and waits. On the first cycle in which in_valid is also high, the accumulator takes in_data and the instruction completes.
- R6: Opcode 6 (output) raises out_valid with out_data equal to the accumulator. It holds both unchanged until out_ready is high, and then completes.
- R7: Opcode 8 (jump) sets PC to twice its operand, truncated to 8 bits.
- R8: Opcode 9 (skip) adds a further 2 to PC when the accumulator is zero, which skips the next instruction. When the accumulator is not zero, PC is left unchanged.
- R9: Opcode 7 (end) retires, and then halted goes high and stays high until reset. While halted there are no retire pulses, in_ready stays low and out_valid stays low.
- R10: An opcode word outside 1 to 9 stops the core without a retire pulse. Opcode 0 and negative values count as outside this range.
- R11: Data memory has 10 words and resets to zero. A store to an address of 10 or more is ignored and changes no word. An address with the top bit set counts as 10 or more. A load from such an address returns 0.
- R12: Each completed instruction gives retire_valid high for exactly one cycle. In that cycle, retire_pc and retire_acc show the PC and the accumulator as that instruction left them.
- R13: The program load port writes program memory only while the core is held in reset. A write while the core is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| prog_we | input | 1 | Program word write strobe, honoured only in reset |
| prog_addr | input | 8 | Program word index |
| prog_data | input | 32 | Program word value |
| in_valid | input | 1 | Input word offered |
| in_data | input | 32 | Input word |
| in_ready | output | 1 | Core waits on an input instruction |
| out_valid | output | 1 | Output word offered |
| out_data | output | 32 | Output word, the accumulator |
| out_ready | input | 1 | Consumer takes the output word |
| retire_valid | output | 1 | One-cycle completion pulse |
| retire_pc | output | 8 | PC after the completed instruction |
| retire_acc | output | 32 | Accumulator after the completed instruction |
| halted | output | 1 | Core stopped until reset |

## Verification
The bench runs a repeated-add multiply that loops through a backward jump. This catches a jump that loads the raw operand instead of twice the operand, and a skip that moves PC by one word; either one sends the loop into misaligned words, or into endless looping, and the program never reaches its END. Separate programs cover the remaining cases:
- Skips taken and not taken with negative and zero accumulators.
- Stores to addresses 10, 12, 16 and all-ones. A design that drops the upper address bits would alias address 16 onto word 0, and the later loads of word 0 would return the stored value instead of 0.
- Unknown opcodes, which must halt the core with no retire pulse.
- A program-port write issued while the core runs, which must not turn an output into a halt.
- Output backpressure, where the accumulator must stay valid and stable until out_ready.

// File: rtl/hacc_pkg.sv
package hacc_pkg;

  typedef enum logic [3:0] {
    OPC_NONE  = 4'd0,
    OPC_LOAD  = 4'd1,
    OPC_ADD   = 4'd2,
    OPC_STORE = 4'd3,
    OPC_SUB   = 4'd4,
    OPC_IN    = 4'd5,
    OPC_OUT   = 4'd6,
    OPC_END   = 4'd7,
    OPC_JMP   = 4'd8,
    OPC_SKIPZ = 4'd9
  } opc_e;

  typedef enum logic [3:0] {
    ST_FETCH,
    ST_READ,
    ST_DECODE,
    ST_EXEC,
    ST_MADDR,
    ST_MDATA,
    ST_MDONE,
    ST_IN,
    ST_OUT,
    ST_HALT
  } state_e;

endpackage

// File: rtl/hacc_imem.sv
module hacc_imem #(
  parameter int W     = 32,
  parameter int DEPTH = 250,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_op,
  output logic [W-1:0]  rd_arg
);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  nxt_addr;

  assign nxt_addr = {1'b0, rd_addr} + (AW+1)'(1);

  always_ff @(posedge clk) begin
    if (wr_en && (int'(wr_addr) < DEPTH)) begin
      mem[wr_addr] <= wr_data;
    end
  end

  always_comb begin
    rd_op  = (int'(rd_addr) < DEPTH)  ? mem[rd_addr]             : '0;
    rd_arg = (int'(nxt_addr) < DEPTH) ? mem[nxt_addr[AW-1:0]]    : '0;
  end

endmodule

// File: rtl/hacc_dmem.sv
module hacc_dmem #(
  parameter int W     = 32,
  parameter int DEPTH = 10,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata
);

  logic [DEPTH-1:0][W-1:0] mem_q;
  logic                    hit;

  assign hit = (addr < W'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else if (we && hit) begin
      mem_q[addr[AW-1:0]] <= wdata;
    end
  end

  assign rdata = hit ? mem_q[addr[AW-1:0]] : '0;

  // R11: a write outside the array leaves every word untouched
  a_r11_oob_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (addr >= W'(DEPTH))) |=> (mem_q == $past(mem_q)));

endmodule

// File: rtl/hacc_alu.sv
module hacc_alu
  import hacc_pkg::*;
#(
  parameter int W = 32
) (
  input  opc_e                opc,
  input  logic signed [W-1:0] acc,
  input  logic signed [W-1:0] operand,
  output logic signed [W-1:0] result
);

  always_comb begin
    unique case (opc)
      OPC_LOAD: result = operand;
      OPC_ADD:  result = acc + operand;
      OPC_SUB:  result = acc - operand;
      default:  result = acc;
    endcase
  end

endmodule

// File: rtl/hacc_core.sv
module hacc_core
  import hacc_pkg::*;
#(
  parameter int  DATA_W     = 32,
  parameter int  IMEM_WORDS = 250,
  parameter int  DMEM_WORDS = 10,
  localparam int IA_W       = $clog2(IMEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_we,
  input  logic [IA_W-1:0]   prog_addr,
  input  logic [DATA_W-1:0] prog_data,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready,
  output logic              retire_valid,
  output logic [IA_W-1:0]   retire_pc,
  output logic [DATA_W-1:0] retire_acc,
  output logic              halted
);

  typedef struct packed {
    logic [DATA_W-1:0] op;
    logic [DATA_W-1:0] arg;
  } iword_t;

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  state_e                    st_q, st_d;
  logic [IA_W-1:0]           pc_q, pc_d;
  logic [IA_W-1:0]           mar1_q, mar1_d;
  iword_t                    mdr1_q, mdr1_d;
  iword_t                    ir_q, ir_d;
  logic [DATA_W-1:0]         mar2_q, mar2_d;
  logic signed [DATA_W-1:0]  mdr2_q, mdr2_d;
  logic signed [DATA_W-1:0]  acc_q, acc_d;
  logic                      retire_q, retire_d;

  logic [DATA_W-1:0]         im_op, im_arg;
  logic [DATA_W-1:0]         dm_rdata;
  logic                      dm_we;
  logic signed [DATA_W-1:0]  alu_res;
  opc_e                      opc;

  hacc_imem #(.W(DATA_W), .DEPTH(IMEM_WORDS)) u_imem (
    .clk     (clk),
    .wr_en   (prog_we && !core_rst_n),
    .wr_addr (prog_addr),
    .wr_data (prog_data),
    .rd_addr (mar1_q),
    .rd_op   (im_op),
    .rd_arg  (im_arg)
  );

  hacc_dmem #(.W(DATA_W), .DEPTH(DMEM_WORDS)) u_dmem (
    .clk   (clk),
    .rst_n (core_rst_n),
    .we    (dm_we),
    .addr  (mar2_q),
    .wdata (mdr2_q),
    .rdata (dm_rdata)
  );

  hacc_alu #(.W(DATA_W)) u_alu (
    .opc     (opc),
    .acc     (acc_q),
    .operand (mdr2_q),
    .result  (alu_res)
  );

  // opcode words with any high bit set decode as unknown
  assign opc = (ir_q.op[DATA_W-1:4] == '0) ? opc_e'(ir_q.op[3:0]) : OPC_NONE;

  always_comb begin
    st_d      = st_q;
    pc_d      = pc_q;
    mar1_d    = mar1_q;
    mdr1_d    = mdr1_q;
    ir_d      = ir_q;
    mar2_d    = mar2_q;
    mdr2_d    = mdr2_q;
    acc_d     = acc_q;
    retire_d  = 1'b0;
    dm_we     = 1'b0;
    in_ready  = 1'b0;
    out_valid = 1'b0;
    unique case (st_q)
      ST_FETCH: begin
        mar1_d = pc_q;
        pc_d   = pc_q + IA_W'(2);
        st_d   = ST_READ;
      end
      ST_READ: begin
        mdr1_d = '{op: im_op, arg: im_arg};
        st_d   = ST_DECODE;
      end
      ST_DECODE: begin
        ir_d = mdr1_q;
        st_d = ST_EXEC;
      end
      ST_EXEC: begin
        unique case (opc)
          OPC_LOAD, OPC_ADD, OPC_SUB, OPC_STORE: st_d = ST_MADDR;
          OPC_IN:  st_d = ST_IN;
          OPC_OUT: st_d = ST_OUT;
          OPC_END: begin
            retire_d = 1'b1;
            st_d     = ST_HALT;
          end
          OPC_JMP: begin
            pc_d     = {ir_q.arg[IA_W-2:0], 1'b0};
            retire_d = 1'b1;
            st_d     = ST_FETCH;
          end
          OPC_SKIPZ: begin
            if (acc_q == '0) pc_d = pc_q + IA_W'(2);
            retire_d = 1'b1;
            st_d     = ST_FETCH;
          end
          default: st_d = ST_HALT;
        endcase
      end
      ST_MADDR: begin
        mar2_d = ir_q.arg;
        st_d   = ST_MDATA;
      end
      ST_MDATA: begin
        mdr2_d = (opc == OPC_STORE) ? acc_q : dm_rdata;
        st_d   = ST_MDONE;
      end
      ST_MDONE: begin
        if (opc == OPC_STORE) dm_we = 1'b1;
        else                  acc_d = alu_res;
        retire_d = 1'b1;
        st_d     = ST_FETCH;
      end
      ST_IN: begin
        in_ready = 1'b1;
        if (in_valid) begin
          acc_d    = in_data;
          retire_d = 1'b1;
          st_d     = ST_FETCH;
        end
      end
      ST_OUT: begin
        out_valid = 1'b1;
        if (out_ready) begin
          retire_d = 1'b1;
          st_d     = ST_FETCH;
        end
      end
      ST_HALT: st_d = ST_HALT;
      default: st_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      st_q     <= ST_FETCH;
      pc_q     <= '0;
      mar1_q   <= '0;
      mdr1_q   <= '0;
      ir_q     <= '0;
      mar2_q   <= '0;
      mdr2_q   <= '0;
      acc_q    <= '0;
      retire_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      pc_q     <= pc_d;
      mar1_q   <= mar1_d;
      mdr1_q   <= mdr1_d;
      ir_q     <= ir_d;
      mar2_q   <= mar2_d;
      mdr2_q   <= mdr2_d;
      acc_q    <= acc_d;
      retire_q <= retire_d;
    end
  end

  assign out_data     = acc_q;
  assign retire_valid = retire_q;
  assign retire_pc    = pc_q;
  assign retire_acc   = acc_q;
  assign halted       = (st_q == ST_HALT);

  // R1: the program counter stays on opcode words
  a_r1_pc_aligned: assert property (@(posedge clk) disable iff (!core_rst_n)
    pc_q[0] == 1'b0);

  // R12: a completion pulse never lasts two cycles
  a_r12_retire_single: assert property (@(posedge clk) disable iff (!core_rst_n)
    retire_valid |=> !retire_valid);

  // R6: an offered output word waits unchanged for the consumer
  a_r6_out_hold: assert property (@(posedge clk) disable iff (!core_rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R5: input and output never wait at the same time
  a_r5_in_out_exclusive: assert property (@(posedge clk) disable iff (!core_rst_n)
    in_ready |-> !out_valid);

  // R7: a jump lands on twice the operand
  a_r7_jump_target: assert property (@(posedge clk) disable iff (!core_rst_n)
    (st_q == ST_EXEC && ir_q.op == DATA_W'(8)) |=>
      (pc_q == {$past(ir_q.arg[IA_W-2:0]), 1'b0}));

  // R8: zero accumulator skips one instruction
  a_r8_skip_taken: assert property (@(posedge clk) disable iff (!core_rst_n)
    (st_q == ST_EXEC && ir_q.op == DATA_W'(9) && acc_q == '0) |=>
      (pc_q == $past(pc_q) + IA_W'(2)));

  // R8: non-zero accumulator leaves the PC alone
  a_r8_skip_not_taken: assert property (@(posedge clk) disable iff (!core_rst_n)
    (st_q == ST_EXEC && ir_q.op == DATA_W'(9) && acc_q != '0) |=> $stable(pc_q));

  // R10: an unknown opcode stops the core with no retire
  a_r10_bad_opcode: assert property (@(posedge clk) disable iff (!core_rst_n)
    (st_q == ST_EXEC && (ir_q.op == '0 || ir_q.op > DATA_W'(9))) |=>
      (halted && !retire_valid));

  // R9: a halted core stays silent
  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!core_rst_n)
    halted |=> (halted && !retire_valid && !in_ready && !out_valid));

endmodule

// File: tb/hacc_core_tb_top.sv
`timescale 1ns/1ps
module hacc_core_tb_top;

  localparam int DW = 32;
  localparam int IW = 250;
  localparam int AW = 8;

  logic          clk;
  logic          rst_n;
  logic          prog_we;
  logic [AW-1:0] prog_addr;
  logic [DW-1:0] prog_data;
  logic          in_valid;
  logic [DW-1:0] in_data;
  logic          in_ready;
  logic          out_valid;
  logic [DW-1:0] out_data;
  logic          out_ready;
  logic          retire_valid;
  logic [AW-1:0] retire_pc;
  logic [DW-1:0] retire_acc;
  logic          halted;

  hacc_core #(.DATA_W(DW), .IMEM_WORDS(IW), .DMEM_WORDS(10)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .prog_we      (prog_we),
    .prog_addr    (prog_addr),
    .prog_data    (prog_data),
    .in_valid     (in_valid),
    .in_data      (in_data),
    .in_ready     (in_ready),
    .out_valid    (out_valid),
    .out_data     (out_data),
    .out_ready    (out_ready),
    .retire_valid (retire_valid),
    .retire_pc    (retire_pc),
    .retire_acc   (retire_acc),
    .halted       (halted)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    int    pc;
    int    acc;
    string tag;
  } exp_t;

  int    checks = 0;
  int    errors = 0;
  int    im_m [IW];
  exp_t  exp_q [$];
  int    out_q [$];
  int    in_src [$];
  int    in_idx;
  int    in_wait;
  int    out_wait;
  bit    prev_ret;
  bit    prev_ov;
  bit    prev_or;
  int    prev_od;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int rd_im(input int idx);
    return (idx < IW) ? im_m[idx] : 0;
  endfunction

  function automatic void push_exp(input int pc, input int a, input string t);
    exp_t e;
    e.pc = pc; e.acc = a; e.tag = t;
    exp_q.push_back(e);
  endfunction

  // driver side: reference interpreter built from the requirements
  task automatic model(input int ins[$]);
    int pc, a, op, arg, ii, steps;
    int dm [10];
    bit run;
    pc = 0; a = 0; ii = 0; steps = 0; run = 1'b1;
    foreach (dm[k]) dm[k] = 0;
    while (run && steps < 5000) begin
      op  = rd_im(pc);
      arg = rd_im(pc + 1);
      pc  = (pc + 2) % 256;
      steps++;
      case (op)
        1: begin a = (arg >= 0 && arg < 10) ? dm[arg] : 0; push_exp(pc, a, "R2 load"); end
        2: begin a = a + ((arg >= 0 && arg < 10) ? dm[arg] : 0); push_exp(pc, a, "R3 add"); end
        4: begin a = a - ((arg >= 0 && arg < 10) ? dm[arg] : 0); push_exp(pc, a, "R3 sub"); end
        3: begin if (arg >= 0 && arg < 10) dm[arg] = a; push_exp(pc, a, "R4 store"); end
        5: begin a = ins[ii]; ii++; push_exp(pc, a, "R5 input"); end
        6: begin out_q.push_back(a); push_exp(pc, a, "R6 output"); end
        7: begin push_exp(pc, a, "R9 end"); run = 1'b0; end
        8: begin pc = (arg * 2) % 256; push_exp(pc, a, "R7 jump"); end
        9: begin if (a == 0) pc = (pc + 2) % 256; push_exp(pc, a, "R8 skip"); end
        default: run = 1'b0;
      endcase
    end
  endtask

  task automatic load_prog(input int words[$]);
    for (int i = 0; i < IW; i++) im_m[i] = (i < words.size()) ? words[i] : 0;
    for (int i = 0; i < IW; i++) begin
      @(negedge clk);
      prog_we   = 1'b1;
      prog_addr = AW'(i);
      prog_data = im_m[i];
    end
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic run_test(input string name, input int prog[$], input int ins[$],
                          input string halt_req, input bit poke);
    int cyc;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(retire_valid == 1'b0, "R12", {name, " reset retire"}, int'(retire_valid), 0);
    chk(halted == 1'b0, "R9", {name, " reset halted"}, int'(halted), 0);
    chk(in_ready == 1'b0 && out_valid == 1'b0, "R5", {name, " reset handshakes"},
        int'(in_ready) + int'(out_valid), 0);
    load_prog(prog);
    exp_q.delete();
    out_q.delete();
    in_src = ins;
    in_idx = 0;
    model(ins);
    @(negedge clk);
    rst_n = 1'b1;
    if (poke) begin
      repeat (6) @(negedge clk);
      prog_we = 1'b1; prog_addr = AW'(2); prog_data = 32'd7;
      @(negedge clk);
      prog_we = 1'b0;
    end
    cyc = 0;
    while (!halted && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    chk(halted == 1'b1, halt_req, {name, " halted"}, int'(halted), 1);
    repeat (12) @(negedge clk);
    chk(exp_q.size() == 0, "R12", {name, " retires outstanding"}, exp_q.size(), 0);
    chk(out_q.size() == 0, "R6", {name, " outputs outstanding"}, out_q.size(), 0);
    chk(!retire_valid && !in_ready && !out_valid && halted, "R9", {name, " quiet after halt"},
        int'(retire_valid) + int'(in_ready) + int'(out_valid), 0);
  endtask

  // monitor side: pops expectations as the design produces results
  always @(negedge clk) begin
    if (rst_n) begin
      if (retire_valid) begin
        if (prev_ret) chk(1'b0, "R12", "retire wider than one cycle", 2, 1);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R12", "unexpected retire pc", int'(retire_pc), -1);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(int'(retire_pc) == e.pc, e.tag, "retire pc", int'(retire_pc), e.pc);
          chk($signed(retire_acc) == e.acc, e.tag, "retire acc", $signed(retire_acc), e.acc);
        end
      end
      prev_ret = retire_valid;

      if (out_valid) begin
        if (prev_ov && !prev_or)
          chk($signed(out_data) == prev_od, "R6", "output held under backpressure",
              $signed(out_data), prev_od);
        if (out_wait >= 2) begin
          out_ready = 1'b1;
          if (out_q.size() == 0) chk(1'b0, "R6", "unexpected output", $signed(out_data), 0);
          else begin
            int ev;
            ev = out_q.pop_front();
            chk($signed(out_data) == ev, "R6", "output value", $signed(out_data), ev);
          end
        end else begin
          out_ready = 1'b0;
        end
        out_wait++;
      end else begin
        out_ready = 1'b0;
        out_wait  = 0;
      end
      prev_ov = out_valid;
      prev_or = out_ready;
      prev_od = $signed(out_data);

      if (in_ready) begin
        if (in_wait >= 1 && in_idx < in_src.size()) begin
          in_valid = 1'b1;
          in_data  = in_src[in_idx];
          in_idx++;
        end else begin
          in_valid = 1'b0;
        end
        in_wait++;
      end else begin
        in_valid = 1'b0;
        in_wait  = 0;
      end
    end else begin
      prev_ret = 1'b0; prev_ov = 1'b0; prev_or = 1'b0;
      out_ready = 1'b0; in_valid = 1'b0; in_wait = 0; out_wait = 0;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired: actual %0d expected %0d", 200000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; prog_we = 1'b0; prog_addr = '0; prog_data = '0;
    in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    prev_ret = 1'b0; prev_ov = 1'b0; prev_or = 1'b0; prev_od = 0;
    in_wait = 0; out_wait = 0; in_idx = 0;

    // R1 R2 R3 R4 R5 R6 R7 R8 R9: repeated-add multiply 6 x 5
    run_test("multiply",
      '{5,0, 3,0, 5,0, 3,1, 5,0, 3,2, 5,0, 3,3,
        1,0, 2,2, 3,0, 1,3, 4,1, 3,3, 9,0, 8,8,
        1,0, 6,0, 7,0},
      '{0, 1, 6, 5}, "R9", 1'b0);

    // R8 R7: skip not taken on negative, taken on zero, jump over END
    run_test("skip",
      '{5,0, 9,0, 6,0, 5,0, 9,0, 6,0, 8,9, 7,0, 6,0, 5,0, 6,0, 7,0},
      '{-3, 0, 42}, "R9", 1'b0);

    // R11: stores to 12, 16 and all-ones ignored; word 9 is the last valid one
    run_test("dm_range",
      '{5,0, 3,12, 1,12, 6,0, 5,0, 3,9, 3,16, 3,-1, 3,10,
        1,0, 6,0, 1,16, 6,0, 1,9, 6,0, 7,0},
      '{77, 9}, "R9", 1'b0);

    // R10: opcode 12 stops without a retire
    run_test("bad_op12", '{5,0, 6,0, 12,3, 7,0}, '{11}, "R10", 1'b0);

    // R10: negative opcode word stops after a load
    run_test("bad_neg", '{5,0, 3,4, 1,4, -1,0, 7,0}, '{-8}, "R10", 1'b0);

    // R13: a program write during the run must not replace OUT with END
    run_test("load_locked", '{5,0, 6,0, 5,0, 6,0, 7,0}, '{4, 8}, "R13", 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule